// File: doc/BRIEF.md
# Add-Only Memory Write Sequencer

This block is the command engine of a one-time-programmable memory slave in which stored bits can only be cleared. It works at byte level. A bus front end hands it each received byte with a strobe, asks it for a byte to send, signals a bus reset, and signals that a programming pulse has been applied. The block holds a byte-wide data array and a small status field, and it has two write commands, one for each.

After a write command the master sends a two-byte starting address and a data byte. It then reads back an 8-bit check code and applies a program pulse. The pulse clears the cell bits that are zero in the data byte. The master then reads the cell back to verify it. The block then steps to the next address and waits for another data byte. On these later passes the check code starts from the low byte of the new address, not from the full frame.

The block never judges whether the master accepted the check code. It acts only on the program pulse and on a bus reset.

Top module: `aow_seq`

## Requirements
- R1: Receiving byte 0Fh in idle selects the data array, and receiving 55h selects the status field. Any other first byte puts the block into a wait-for-bus-reset state, in which every read returns FFh.
- R2: On the first pass, the check code starts at 00h and takes in the command byte, the low address byte, the high address byte and the data byte, in that order. It uses polynomial x^8+x^5+x^4+1 with each byte taken least significant bit first. After the data byte, the master reads this code.
- R3: On every later pass, the check code is loaded with the low byte of the incremented address, and then only the new data byte is shifted in.
- R4: A `tx_req` pulse gives a `tx_valid` pulse in the next cycle, with `tx_data` loaded at the same time. When the block is neither waiting for the check-code read nor for the verify read, `tx_data` is FFh.
- R5: A program pulse in the wait-for-program state (the state after the check-code read) clears every cell bit that is 0 in the data byte and leaves every other bit unchanged. The cell therefore equals the AND of all bytes programmed into it.
- R6: A program pulse in any other state changes no cell.
- R7: After the program pulse, the next read returns the addressed cell's current contents.
- R8: The address increments after every verify read, whether or not the cell matched the data. Data-array writes use address bits 6:0, so a cell is selected by the address modulo 128. Status writes use address bits 2:0.
- R9: After the verify read at the last location (data index 127 or status index 7), the address does not increment and the block waits for a bus reset.
- R10: A bus reset in any state returns the block to idle, where it waits for a command. A reset in the same cycle as another strobe takes priority, and stored cells keep their values.
- R11: After `rst_n`, every data-array cell reads FFh, status bytes 0 to 6 read FFh, and status byte 7 always reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_reset | input | 1 | One-cycle strobe: bus reset seen |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Byte received from the master |
| tx_req | input | 1 | One-cycle strobe: master starts reading a byte |
| tx_valid | output | 1 | Response strobe, one cycle after `tx_req` |
| tx_data | output | 8 | Byte to send, LSB first on the bus |
| prog_pulse | input | 1 | One-cycle strobe: programming pulse applied |

## Verification
Every result appears one clock edge after its stimulus. `tx_valid` and `tx_data` are registered on the edge that samples `tx_req`. A cell change is visible through the verify read that follows the program strobe's edge. The bench holds each strobe high from one falling edge to the next. It samples the outputs at the second falling edge, which lies after exactly one rising edge. Expected check codes come from a bench-side model of the polynomial. Expected cell contents come from a vector table plus an AND model across repeated passes.

// File: rtl/aow_pkg.sv
// Shared definitions for the add-only write sequencer.
// Assumes bytes enter the check code least significant bit first.
package aow_pkg;

    localparam logic [7:0] CMD_WR_ARRAY  = 8'h0F;
    localparam logic [7:0] CMD_WR_STATUS = 8'h55;
    localparam logic [7:0] IDLE_BYTE     = 8'hFF;
    localparam logic [7:0] CRC_POLY_REFL = 8'h8C;  // x^8+x^5+x^4+1, reflected

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ADDR_LO,
        SQ_ADDR_HI,
        SQ_DATA,
        SQ_CRC_RD,
        SQ_PROG_WAIT,
        SQ_VFY_RD,
        SQ_HALT
    } seq_state_t;

    // Advance the check code by one byte, LSB first.
    function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in,
                                             input logic [7:0] din);
        logic [7:0] acc;
        acc = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (acc[0] ^ din[b]) acc = (acc >> 1) ^ CRC_POLY_REFL;
            else                 acc = acc >> 1;
        end
        return acc;
    endfunction

endpackage

// File: rtl/aow_crc8.sv
// Check-code register. Seed loading and byte shifting can happen in the same
// cycle; the shift then starts from the seed.
// Assumes the controller never asks for a shift without a valid byte.
module aow_crc8 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] seed,
    input  logic       shift,
    input  logic [7:0] din,
    output logic [7:0] crc
);
    import aow_pkg::*;

    logic [7:0] base_w;

    // Pick the starting value: the fresh seed or the running code.
    always_comb base_w = load ? seed : crc;

    // Hold or advance the running code.
    always_ff @(posedge clk) begin
        if (!rst_n)     crc <= 8'h00;
        else if (shift) crc <= crc8_byte(base_w, din);
        else            crc <= base_w;
    end
endmodule

// File: rtl/aow_cells.sv
// Add-only storage: a data array and a status field. A write can only clear
// bits (AND with the new byte). The last status byte is fixed at zero.
// Assumes both depths are powers of two.
module aow_cells #(
    parameter int ARRAY_DEPTH  = 128,
    parameter int STATUS_DEPTH = 8,
    localparam int AIW = $clog2(ARRAY_DEPTH),
    localparam int SIW = $clog2(STATUS_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_status,
    input  logic [AIW-1:0] arr_idx,
    input  logic [SIW-1:0] stat_idx,
    input  logic           we,
    input  logic [7:0]     wdata,
    output logic [7:0]     rd_data
);
    logic [7:0] arr_q  [ARRAY_DEPTH];
    logic [7:0] stat_w [STATUS_DEPTH];

    // Data array: power-on erased to FFh, AND-only updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ARRAY_DEPTH; i++) arr_q[i] <= 8'hFF;
        end else if (we && !sel_status) begin
            arr_q[arr_idx] <= arr_q[arr_idx] & wdata;
        end
    end

    // Status field: erasable bytes plus one fixed zero byte at the top.
    for (genvar g = 0; g < STATUS_DEPTH; g++) begin : g_stat
        if (g == STATUS_DEPTH - 1) begin : g_fixed
            assign stat_w[g] = 8'h00;
        end else begin : g_cell
            logic [7:0] cell_q;
            // One status byte: erased at power-on, AND-only updates.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= 8'hFF;
                else if (we && sel_status && (stat_idx == SIW'(g)))
                    cell_q <= cell_q & wdata;
            end
            assign stat_w[g] = cell_q;
        end
    end

    // Read the addressed cell of the selected space.
    always_comb rd_data = sel_status ? stat_w[stat_idx] : arr_q[arr_idx];
endmodule

// File: rtl/aow_ctrl.sv
// Command sequencer: decodes the command, collects the address and the data,
// steers the check code, gates the program strobe and steps the address.
// Assumes the strobes are one cycle wide and a bus reset outranks them all.
module aow_ctrl #(
    parameter int ARRAY_DEPTH  = 128,
    parameter int STATUS_DEPTH = 8,
    parameter int ADDR_W       = 16,
    localparam int AIW = $clog2(ARRAY_DEPTH),
    localparam int SIW = $clog2(STATUS_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_reset,
    input  logic                rx_valid,
    input  logic [7:0]          rx_byte,
    input  logic                tx_req,
    input  logic                prog_pulse,
    output aow_pkg::seq_state_t state,
    output logic                sel_status,
    output logic [AIW-1:0]      arr_idx,
    output logic [SIW-1:0]      stat_idx,
    output logic                cell_we,
    output logic [7:0]          wdata,
    output logic                crc_load,
    output logic [7:0]          crc_seed,
    output logic                crc_shift,
    output logic [7:0]          crc_din
);
    import aow_pkg::*;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_inc;
    logic [7:0]        data_q;
    logic              at_last;
    logic              cmd_ok;

    // Decode the command, derive the next address, and detect the last location.
    always_comb begin
        cmd_ok   = (rx_byte == CMD_WR_ARRAY) || (rx_byte == CMD_WR_STATUS);
        addr_inc = addr_q + 1'b1;
        at_last  = sel_status ? (addr_q[SIW-1:0] == SIW'(STATUS_DEPTH - 1))
                              : (addr_q[AIW-1:0] == AIW'(ARRAY_DEPTH - 1));
    end

    // Sequence state, address counter and data latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            addr_q     <= '0;
            sel_status <= 1'b0;
            data_q     <= 8'hFF;
        end else if (bus_reset) begin
            state <= SQ_IDLE;
        end else begin
            case (state)
                SQ_IDLE: if (rx_valid) begin
                    sel_status <= (rx_byte == CMD_WR_STATUS);
                    state      <= cmd_ok ? SQ_ADDR_LO : SQ_HALT;
                end
                SQ_ADDR_LO: if (rx_valid) begin
                    addr_q[7:0] <= rx_byte;
                    state       <= SQ_ADDR_HI;
                end
                SQ_ADDR_HI: if (rx_valid) begin
                    addr_q[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
                    state              <= SQ_DATA;
                end
                SQ_DATA: if (rx_valid) begin
                    data_q <= rx_byte;
                    state  <= SQ_CRC_RD;
                end
                SQ_CRC_RD:    if (tx_req)     state <= SQ_PROG_WAIT;
                SQ_PROG_WAIT: if (prog_pulse) state <= SQ_VFY_RD;
                SQ_VFY_RD: if (tx_req) begin
                    if (at_last) begin
                        state <= SQ_HALT;
                    end else begin
                        addr_q <= addr_inc;
                        state  <= SQ_DATA;
                    end
                end
                default: state <= SQ_HALT;
            endcase
        end
    end

    // Check-code steering: restart on a command, shift frame bytes, reseed per pass.
    always_comb begin
        crc_load  = 1'b0;
        crc_seed  = 8'h00;
        crc_shift = 1'b0;
        crc_din   = rx_byte;
        if (!bus_reset) begin
            case (state)
                SQ_IDLE: if (rx_valid && cmd_ok) begin
                    crc_load  = 1'b1;
                    crc_shift = 1'b1;
                end
                SQ_ADDR_LO, SQ_ADDR_HI, SQ_DATA: crc_shift = rx_valid;
                SQ_VFY_RD: if (tx_req && !at_last) begin
                    crc_load = 1'b1;
                    crc_seed = addr_inc[7:0];
                end
                default: ;
            endcase
        end
    end

    // Storage controls: a program strobe counts only while awaiting it.
    always_comb begin
        cell_we  = (state == SQ_PROG_WAIT) && prog_pulse && !bus_reset;
        wdata    = data_q;
        arr_idx  = addr_q[AIW-1:0];
        stat_idx = addr_q[SIW-1:0];
    end
endmodule

// File: rtl/aow_seq.sv
// Top of the add-only write sequencer: controller, check-code register,
// storage and the registered transmit byte.
// Assumes a byte-level front end that handles slot timing and the programming voltage.
module aow_seq #(
    parameter int ARRAY_DEPTH  = 128,
    parameter int STATUS_DEPTH = 8,
    parameter int ADDR_W       = 16,
    localparam int AIW = $clog2(ARRAY_DEPTH),
    localparam int SIW = $clog2(STATUS_DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       prog_pulse
);
    import aow_pkg::*;

    seq_state_t     state_w;
    logic           sel_status_w;
    logic [AIW-1:0] arr_idx_w;
    logic [SIW-1:0] stat_idx_w;
    logic           cell_we_w;
    logic [7:0]     wdata_w;
    logic [7:0]     cell_rd_w;
    logic           crc_load_w;
    logic [7:0]     crc_seed_w;
    logic           crc_shift_w;
    logic [7:0]     crc_din_w;
    logic [7:0]     crc_w;

    aow_ctrl #(
        .ARRAY_DEPTH (ARRAY_DEPTH),
        .STATUS_DEPTH(STATUS_DEPTH),
        .ADDR_W      (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_req    (tx_req),
        .prog_pulse(prog_pulse),
        .state     (state_w),
        .sel_status(sel_status_w),
        .arr_idx   (arr_idx_w),
        .stat_idx  (stat_idx_w),
        .cell_we   (cell_we_w),
        .wdata     (wdata_w),
        .crc_load  (crc_load_w),
        .crc_seed  (crc_seed_w),
        .crc_shift (crc_shift_w),
        .crc_din   (crc_din_w)
    );

    aow_crc8 u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .load (crc_load_w),
        .seed (crc_seed_w),
        .shift(crc_shift_w),
        .din  (crc_din_w),
        .crc  (crc_w)
    );

    aow_cells #(
        .ARRAY_DEPTH (ARRAY_DEPTH),
        .STATUS_DEPTH(STATUS_DEPTH)
    ) u_cells (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_status(sel_status_w),
        .arr_idx   (arr_idx_w),
        .stat_idx  (stat_idx_w),
        .we        (cell_we_w),
        .wdata     (wdata_w),
        .rd_data   (cell_rd_w)
    );

    // Answer each read request one cycle later with the byte for the current state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= IDLE_BYTE;
        end else begin
            tx_valid <= tx_req;
            if (tx_req) begin
                if (bus_reset)                  tx_data <= IDLE_BYTE;
                else if (state_w == SQ_CRC_RD)  tx_data <= crc_w;
                else if (state_w == SQ_VFY_RD)  tx_data <= cell_rd_w;
                else                            tx_data <= IDLE_BYTE;
            end
        end
    end
endmodule

// File: rtl/aow_seq_chk.sv
// Property checker for the add-only write sequencer, bound into the top.
// Assumes it sees the controller state, the storage strobe and the cell read port.
module aow_seq_chk #(
    parameter int AIW = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_reset,
    input logic                tx_req,
    input logic                tx_valid,
    input aow_pkg::seq_state_t state,
    input logic                cell_we,
    input logic [7:0]          cell_rd,
    input logic [AIW-1:0]      arr_idx
);
    import aow_pkg::*;

    // R4
    tx_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);

    // R10
    bus_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state == SQ_IDLE));

    // R5
    bits_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cell_we |=> ((cell_rd & ~$past(cell_rd)) == 8'h00));

    // R7
    write_then_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_we && !bus_reset) |=> (state == SQ_VFY_RD));

    // R8
    addr_hold_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_PROG_WAIT) |=> $stable(arr_idx));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == SQ_HALT) && !bus_reset) |=> (state == SQ_HALT));
endmodule

bind aow_seq aow_seq_chk #(.AIW(AIW)) u_aow_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_reset(bus_reset),
    .tx_req   (tx_req),
    .tx_valid (tx_valid),
    .state    (state_w),
    .cell_we  (cell_we_w),
    .cell_rd  (cell_rd_w),
    .arr_idx  (arr_idx_w)
);

// File: tb/test_aow_seq.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of single-pass writes, then directed
// tests for multi-pass check codes, last locations, aborts and ignored strobes.
module test_aow_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       prog_pulse = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    aow_seq i_aow_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_req    (tx_req),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .prog_pulse(prog_pulse)
    );

    // Reference check code: x^8+x^5+x^4+1, LSB first.
    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = r[0] ^ d[k];
            r  = {1'b0, r[7:1]};
            if (fb) r = r ^ 8'b1000_1100;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic pulse_prog();
        @(negedge clk); prog_pulse = 1'b1;
        @(negedge clk); prog_pulse = 1'b0;
    endtask

    // Read one byte; sampled at the falling edge after the answering rising edge.
    task automatic read_byte(input string req, output logic [7:0] b);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        check({req, " tx_valid"}, {7'd0, tx_valid}, 8'h01);
        b = tx_data;
    endtask

    task automatic first_pass(input logic stat, input logic [15:0] a, input logic [7:0] d,
                              output logic [7:0] crc, output logic [7:0] vfy);
        logic [7:0] cmd;
        cmd = stat ? 8'h55 : 8'h0F;
        send(cmd); send(a[7:0]); send(a[15:8]); send(d);
        read_byte("R2", crc);
        pulse_prog();
        read_byte("R7", vfy);
    endtask

    task automatic next_pass(input logic [7:0] d, output logic [7:0] crc, output logic [7:0] vfy);
        send(d);
        read_byte("R3", crc);
        pulse_prog();
        read_byte("R7", vfy);
    endtask

    function automatic logic [7:0] frame_crc(input logic stat, input logic [15:0] a, input logic [7:0] d);
        return ref_crc(ref_crc(ref_crc(ref_crc(8'h00, stat ? 8'h55 : 8'h0F), a[7:0]), a[15:8]), d);
    endfunction

    // Vector: {status select, address, data, expected verify byte}.
    localparam int NVEC = 8;
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 16'h0010, 8'hA5, 8'hA5},
        {1'b0, 16'h0010, 8'h3C, 8'h24},
        {1'b0, 16'h0010, 8'hFF, 8'h24},
        {1'b0, 16'h0190, 8'h0F, 8'h04},
        {1'b1, 16'h0002, 8'hF0, 8'hF0},
        {1'b1, 16'h0002, 8'h55, 8'h50},
        {1'b1, 16'h0007, 8'hFF, 8'h00},
        {1'b0, 16'h007F, 8'h81, 8'h81}
    };

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [7:0] c, v, r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: quiet after reset; an idle read returns FFh.
        check("R4 idle tx_valid", {7'd0, tx_valid}, 8'h00);
        read_byte("R4", r);
        check("R4 idle read", r, 8'hFF);

        // R11: erased status byte and erased array cell.
        first_pass(1'b1, 16'h0003, 8'hFF, c, v);
        check("R11 status erased", v, 8'hFF);
        pulse_reset();
        first_pass(1'b0, 16'h0055, 8'hFF, c, v);
        check("R11 array erased", v, 8'hFF);

        // Vector table: R2 frame code, R5/R8/R11 cell contents.
        for (int i = 0; i < NVEC; i++) begin
            logic        vs;
            logic [15:0] va;
            logic [7:0]  vd, ve;
            {vs, va, vd, ve} = VEC[i];
            pulse_reset();
            first_pass(vs, va, vd, c, v);
            check("R2 frame crc", c, frame_crc(vs, va, vd));
            check("R5 and-only cell", v, ve);
        end

        // R3: later passes reseed from the incremented low address byte.
        pulse_reset();
        first_pass(1'b0, 16'h0020, 8'h11, c, v);
        check("R2 multi first crc", c, frame_crc(1'b0, 16'h0020, 8'h11));
        check("R7 multi first", v, 8'h11);
        next_pass(8'h22, c, v);
        check("R3 pass2 crc", c, ref_crc(8'h21, 8'h22));
        check("R7 pass2 verify", v, 8'h22);
        next_pass(8'h33, c, v);
        check("R3 pass3 crc", c, ref_crc(8'h22, 8'h33));
        check("R7 pass3 verify", v, 8'h33);

        // R8: a mismatching verify still advances; R10: cells survive bus resets.
        pulse_reset();
        first_pass(1'b0, 16'h0020, 8'hFF, c, v);
        check("R10 cell kept", v, 8'h11);
        next_pass(8'hF0, c, v);
        check("R8 increment after mismatch", c, ref_crc(8'h21, 8'hF0));
        check("R5 and with earlier", v, 8'h20);

        // R9: the last status location halts the sequence.
        pulse_reset();
        first_pass(1'b1, 16'h0006, 8'hAA, c, v);
        check("R5 status 6", v, 8'hAA);
        next_pass(8'h00, c, v);
        check("R3 reseed at 07", c, ref_crc(8'h07, 8'h00));
        check("R11 fixed status byte", v, 8'h00);
        read_byte("R9", r);
        check("R9 halted after status 7", r, 8'hFF);
        send(8'h12);
        read_byte("R9", r);
        check("R9 data ignored when halted", r, 8'hFF);

        // R9: the last array location halts the sequence.
        pulse_reset();
        first_pass(1'b0, 16'h007F, 8'hFF, c, v);
        check("R5 cell 127 kept", v, 8'h81);
        read_byte("R9", r);
        check("R9 halted after index 127", r, 8'hFF);

        // R1: an unknown command waits for a reset.
        pulse_reset();
        send(8'h33); send(8'h00); send(8'h00); send(8'hAA);
        read_byte("R1", r);
        check("R1 unknown cmd", r, 8'hFF);
        pulse_reset();
        first_pass(1'b0, 16'h0030, 8'h77, c, v);
        check("R1 valid after reset", c, frame_crc(1'b0, 16'h0030, 8'h77));

        // R6: program strobes outside the wait-for-program state are ignored.
        pulse_reset();
        pulse_prog();
        send(8'h0F); send(8'h40); send(8'h00);
        pulse_prog();
        send(8'h00);
        pulse_prog();
        read_byte("R6", c);
        pulse_reset();
        first_pass(1'b0, 16'h0040, 8'hFF, c, v);
        check("R6 stray prog ignored", v, 8'hFF);

        // R10: an abort mid-frame restarts from idle with a fresh frame code.
        pulse_reset();
        send(8'h0F); send(8'h41);
        pulse_reset();
        first_pass(1'b0, 16'h0041, 8'h5A, c, v);
        check("R10 crc after abort", c, frame_crc(1'b0, 16'h0041, 8'h5A));
        check("R10 write after abort", v, 8'h5A);

        // R10: a bus reset beats a simultaneous program strobe.
        pulse_reset();
        send(8'h0F); send(8'h42); send(8'h00); send(8'h00);
        read_byte("R2", c);
        @(negedge clk); prog_pulse = 1'b1; bus_reset = 1'b1;
        @(negedge clk); prog_pulse = 1'b0; bus_reset = 1'b0;
        first_pass(1'b0, 16'h0042, 8'hFF, c, v);
        check("R10 reset beats prog", v, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule